// File: doc/BRIEF.md
# Streaming Pattern Checker

This block sits at the far end of a multi-channel streaming path and checks that the data it receives follows a known sequence. For each channel the expected value is a counter. The counter restarts at zero on a start-of-packet beat and steps by one on every accepted beat. Because each channel keeps its own counter and open-packet flag, fragments of packets from different channels may arrive interleaved.

Each beat can raise at most one exception: a data mismatch, a missing start-of-packet, a missing end-of-packet, or an asserted input error flag. The exception is written as a descriptor into a 32-entry queue. A repeat of the type most recently detected is not queued again, and exceptions that arrive while the queue is full are dropped.

Software uses a 32-bit register port to control the block. It enables acceptance, sets an 8-bit throttle that limits how often ready is asserted, reads the build-time settings, and pops exception descriptors one at a time.

Top module: `stream_pattern_checker`

## Requirements
- R1: `in_ready` is low in every cycle while the enable bit (control register at offset 0x0, bit 0) is 0; after reset that bit is 0.
- R2: With throttle value T (control register bits [15:8]) and enable set, `in_ready` is high in exactly T of any 256 consecutive cycles, so T = 0 keeps it low.
- R3: A beat is taken only in a cycle where `in_valid` and `in_ready` are both high; a beat presented while `in_ready` is low changes no channel state and queues nothing.
- R4: On each channel the expected data is 0 on a start-of-packet beat and one more than the previous accepted beat's expected value otherwise; a difference raises type 1 (data mismatch).
- R5: A beat without start-of-packet on a channel with no open packet raises type 2 (missing start); its data is not compared and the channel stays closed.
- R6: A start-of-packet beat on a channel whose packet is still open raises type 3 (missing end) and opens a new packet with expected value 0.
- R7: A beat with any `in_error` bit set raises type 4, unless another type applies; at most one exception per beat, with priority type 3, then 2, then 1, then 4.
- R8: Each channel keeps its own expected value and open flag, so interleaved beats of different channels are checked independently.
- R9: An exception whose type equals the type of the previous detected exception is not queued, whether or not that earlier one was queued.
- R10: The queue holds 32 descriptors; exceptions detected while it is full are discarded and the stored entries are unchanged.
- R11: A read of offset 0x8 returns the oldest descriptor (type in bits [3:0], channel in bits [15:8], other bits 0) and removes it; on an empty queue it returns 0 and removes nothing.
- R12: Offset 0x4 reads the channel count in bits [7:0] and the packet-support setting in bit 16; offset 0x0 reads back enable in bit 0 and throttle in bits [15:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Checker ready for a beat |
| in_data | input | DATA_W | Beat data |
| in_channel | input | CH_W | Channel of the beat |
| in_sop | input | 1 | Start of packet |
| in_eop | input | 1 | End of packet |
| in_error | input | ERR_W | Error flags carried with the beat |
| csr_addr | input | 4 | Register byte offset |
| csr_write | input | 1 | Register write strobe |
| csr_wdata | input | 32 | Register write data |
| csr_read | input | 1 | Register read strobe (pops at offset 0x8) |
| csr_rdata | output | 32 | Register read data, valid in the cycle of the read |

## Verification
The assertions check in every cycle that ready stays low while acceptance is disabled or the throttle is zero, and that no exception is raised without a handshake. They also check that a queued descriptor never repeats the previous detected type, that a full queue does not grow, and that an empty read returns zero. The expected sequence on each channel, the priority between exception types, the interleaving of channels, the exact ready count per throttle window and the order in which descriptors are returned can only be shown by the bench's scenarios.

// File: rtl/spc_pkg.sv
// Shared types for the streaming pattern checker.
package spc_pkg;
    typedef enum logic [3:0] {
        EXC_NONE  = 4'd0,
        EXC_DATA  = 4'd1,
        EXC_NOSOP = 4'd2,
        EXC_NOEOP = 4'd3,
        EXC_ERRIN = 4'd4
    } exc_e;

    localparam int DESC_W = 16;
endpackage

// File: rtl/spc_throttle.sv
// Ready generator: a free-running counter gates ready so that it is high
// in THR_W-bit window slots below the throttle value.
// Assumes: throttle and enable are stable register outputs.
module spc_throttle #(
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [THR_W-1:0] throttle,
    output logic             ready
);
    logic [THR_W-1:0] slot_q;

    // free-running slot counter
    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_q + 1'b1;
    end

    // ready only in slots below the throttle
    always_comb ready = enable && (slot_q < throttle);
endmodule

// File: rtl/spc_chan_tracker.sv
// Per-channel pattern tracker: holds an open flag and an expected value
// for each channel and classifies each accepted beat into one exception.
// Assumes: beat is the valid/ready handshake; in_channel < NUM_CH.
module spc_chan_tracker
    import spc_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int DATA_W  = 8,
    parameter int ERR_W   = 1,
    parameter bit HAS_PKT = 1'b1,
    parameter int CH_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat,
    input  logic [CH_W-1:0]   channel,
    input  logic [DATA_W-1:0] data,
    input  logic              sop,
    input  logic              eop,
    input  logic [ERR_W-1:0]  err,
    output logic              exc_valid,
    output exc_e              exc_type
);
    logic [NUM_CH-1:0] open_q;
    logic [DATA_W-1:0] expect_q [NUM_CH];
    logic              use_sop, use_eop, cur_open;
    logic [DATA_W-1:0] cur_expect;

    assign use_sop = HAS_PKT && sop;
    assign use_eop = HAS_PKT && eop;

    // select the state of the addressed channel
    always_comb begin
        cur_open   = 1'b0;
        cur_expect = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (channel == CH_W'(c)) begin
                cur_open   = HAS_PKT ? open_q[c] : 1'b1;
                cur_expect = use_sop ? '0 : expect_q[c];
            end
        end
    end

    // classify the beat, one exception at most, fixed priority
    always_comb begin
        exc_type = EXC_NONE;
        if (beat) begin
            if (use_sop && cur_open)        exc_type = EXC_NOEOP;
            else if (!use_sop && !cur_open) exc_type = EXC_NOSOP;
            else if (data != cur_expect)    exc_type = EXC_DATA;
            else if (|err)                  exc_type = EXC_ERRIN;
        end
        exc_valid = (exc_type != EXC_NONE);
    end

    // per-channel state update on accepted beats
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q[c]   <= 1'b0;
                expect_q[c] <= '0;
            end else if (beat && channel == CH_W'(c)) begin
                if (use_sop) begin
                    expect_q[c] <= DATA_W'(1);
                    open_q[c]   <= !use_eop;
                end else if (cur_open) begin
                    expect_q[c] <= expect_q[c] + 1'b1;
                    if (use_eop) open_q[c] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/spc_desc_fifo.sv
// Exception descriptor queue: circular buffer with show-ahead head.
// Assumes: push is never asserted when full (caller gates it).
module spc_desc_fifo #(
    parameter int DEPTH  = 32,
    parameter int WIDTH  = 16,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;

    assign count = cnt_q;
    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign empty = (cnt_q == '0);
    assign head  = mem_q[rd_q];

    // storage write
    always_ff @(posedge clk) begin
        if (push) mem_q[wr_q] <= push_data;
    end

    // pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (pop)  rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
        end
    end
endmodule

// File: rtl/stream_pattern_checker.sv
// Top: streaming pattern checker with register port and exception queue.
// Assumes: registers are read combinationally in the cycle of csr_read;
// a read of offset 0x8 pops at the clock edge that ends that cycle.
module stream_pattern_checker
    import spc_pkg::*;
#(
    parameter int  NUM_CH  = 4,
    parameter int  DATA_W  = 8,
    parameter int  ERR_W   = 1,
    parameter bit  HAS_PKT = 1'b1,
    parameter int  QDEPTH  = 32,
    parameter int  THR_W   = 8,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CH_W-1:0]   in_channel,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [ERR_W-1:0]  in_error,
    input  logic [3:0]        csr_addr,
    input  logic              csr_write,
    input  logic [31:0]       csr_wdata,
    input  logic              csr_read,
    output logic [31:0]       csr_rdata
);
    localparam int CNT_W = $clog2(QDEPTH + 1);
    localparam logic [3:0] OFS_CTRL = 4'h0;
    localparam logic [3:0] OFS_INFO = 4'h4;
    localparam logic [3:0] OFS_EXC  = 4'h8;

    logic             ctl_en;
    logic [THR_W-1:0] thr;
    logic             beat;
    logic             exc_valid;
    exc_e             exc_type;
    exc_e             last_type_q;
    logic             q_push, q_pop, q_full, q_empty;
    logic [CNT_W-1:0] q_count;
    logic [DESC_W-1:0] q_head, q_wdata;

    // control register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_en <= 1'b0;
            thr    <= '0;
        end else if (csr_write && csr_addr == OFS_CTRL) begin
            ctl_en <= csr_wdata[0];
            thr    <= csr_wdata[8 +: THR_W];
        end
    end

    spc_throttle #(.THR_W(THR_W)) u_thr (
        .clk(clk), .rst_n(rst_n), .enable(ctl_en), .throttle(thr), .ready(in_ready)
    );

    assign beat = in_valid && in_ready;

    spc_chan_tracker #(
        .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ERR_W(ERR_W),
        .HAS_PKT(HAS_PKT), .CH_W(CH_W)
    ) u_trk (
        .clk(clk), .rst_n(rst_n), .beat(beat), .channel(in_channel),
        .data(in_data), .sop(in_sop), .eop(in_eop), .err(in_error),
        .exc_valid(exc_valid), .exc_type(exc_type)
    );

    // remember the most recently detected exception type
    always_ff @(posedge clk) begin
        if (!rst_n)         last_type_q <= EXC_NONE;
        else if (exc_valid) last_type_q <= exc_type;
    end

    assign q_push  = exc_valid && (exc_type != last_type_q) && !q_full;
    assign q_wdata = {8'(in_channel), 4'b0, exc_type};
    assign q_pop   = csr_read && (csr_addr == OFS_EXC) && !q_empty;

    spc_desc_fifo #(.DEPTH(QDEPTH), .WIDTH(DESC_W)) u_q (
        .clk(clk), .rst_n(rst_n), .push(q_push), .push_data(q_wdata),
        .pop(q_pop), .head(q_head), .full(q_full), .empty(q_empty), .count(q_count)
    );

    // register read mux
    always_comb begin
        csr_rdata = '0;
        if (csr_read) begin
            case (csr_addr)
                OFS_CTRL: csr_rdata = {16'b0, 8'(thr), 7'b0, ctl_en};
                OFS_INFO: csr_rdata = {15'b0, HAS_PKT, 8'b0, 8'(NUM_CH)};
                OFS_EXC:  csr_rdata = q_empty ? '0 : {16'b0, q_head};
                default:  csr_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/spc_checker.sv
// Assertion checker for stream_pattern_checker, bound into the top.
module spc_checker #(
    parameter int THR_W = 8,
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             ctl_en,
    input logic [THR_W-1:0] thr,
    input logic             exc_valid,
    input logic [3:0]       exc_type,
    input logic             q_push,
    input logic             q_pop,
    input logic             q_full,
    input logic             q_empty,
    input logic [CNT_W-1:0] q_count,
    input logic             csr_read,
    input logic [3:0]       csr_addr,
    input logic [31:0]      csr_rdata
);
    logic [3:0] prev_det_q;

    // track the previous detected type independently of the design
    always_ff @(posedge clk) begin
        if (!rst_n)         prev_det_q <= 4'd0;
        else if (exc_valid) prev_det_q <= exc_type;
    end

    // R1
    ready_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |-> !in_ready);

    // R2
    thr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr == '0) |-> !in_ready);

    // R3
    no_beat_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |-> !exc_valid);

    // R9
    no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_push |-> (exc_type != prev_det_q));

    // R10
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && !q_pop) |=> (q_count == $past(q_count)));

    // R11
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_read && csr_addr == 4'h8 && q_empty) |-> (csr_rdata == 32'd0 && !q_pop));
endmodule

bind stream_pattern_checker spc_checker #(.THR_W(THR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .ctl_en(ctl_en), .thr(thr), .exc_valid(exc_valid), .exc_type(exc_type),
    .q_push(q_push), .q_pop(q_pop), .q_full(q_full), .q_empty(q_empty),
    .q_count(q_count), .csr_read(csr_read), .csr_addr(csr_addr), .csr_rdata(csr_rdata)
);

// File: tb/stream_pattern_checker_test.sv
// Self-checking bench: a vector table of beats with the expected exception,
// then directed tests for reset, throttle, ignored beats and a full queue.
module stream_pattern_checker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic [1:0]  in_channel = '0;
    logic        in_sop = 1'b0, in_eop = 1'b0;
    logic [0:0]  in_error = '0;
    logic [3:0]  csr_addr = '0;
    logic        csr_write = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic        csr_read = 1'b0;
    logic [31:0] csr_rdata;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    stream_pattern_checker uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_channel(in_channel), .in_sop(in_sop),
        .in_eop(in_eop), .in_error(in_error), .csr_addr(csr_addr),
        .csr_write(csr_write), .csr_wdata(csr_wdata), .csr_read(csr_read),
        .csr_rdata(csr_rdata)
    );

    typedef struct packed {
        logic [1:0] ch;
        logic [7:0] d;
        logic       sop;
        logic       eop;
        logic       err;
        logic [3:0] exp;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 8'd0, 1'b1, 1'b0, 1'b0, 4'd0},  // R4 open ch0
        '{2'd1, 8'd0, 1'b1, 1'b0, 1'b0, 4'd0},  // R8 open ch1
        '{2'd0, 8'd1, 1'b0, 1'b0, 1'b0, 4'd0},  // R8 interleaved
        '{2'd1, 8'd1, 1'b0, 1'b0, 1'b0, 4'd0},
        '{2'd0, 8'd5, 1'b0, 1'b0, 1'b0, 4'd1},  // R4 mismatch
        '{2'd1, 8'd2, 1'b0, 1'b1, 1'b0, 4'd0},  // close ch1
        '{2'd1, 8'd0, 1'b0, 1'b0, 1'b0, 4'd2},  // R5 missing start
        '{2'd0, 8'd3, 1'b0, 1'b0, 1'b1, 4'd4},  // R7 input error
        '{2'd0, 8'd0, 1'b1, 1'b0, 1'b0, 4'd3},  // R6 missing end
        '{2'd0, 8'd1, 1'b0, 1'b1, 1'b0, 4'd0},
        '{2'd2, 8'd7, 1'b0, 1'b0, 1'b0, 4'd2},  // R5
        '{2'd3, 8'd9, 1'b0, 1'b0, 1'b0, 4'd0},  // R9 repeat suppressed
        '{2'd2, 8'd0, 1'b1, 1'b1, 1'b0, 4'd0},  // single-beat packet
        '{2'd3, 8'd0, 1'b1, 1'b0, 1'b0, 4'd0},
        '{2'd3, 8'd4, 1'b0, 1'b0, 1'b0, 4'd1},  // R4
        '{2'd3, 8'd5, 1'b0, 1'b1, 1'b0, 4'd0}   // R9 repeat suppressed
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic csr_wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        csr_addr = a; csr_wdata = v; csr_write = 1'b1;
        @(posedge clk); #1;
        csr_write = 1'b0;
    endtask

    task automatic csr_rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        csr_addr = a; csr_read = 1'b1;
        #1 v = csr_rdata;
        @(posedge clk); #1;
        csr_read = 1'b0;
    endtask

    task automatic send(input logic [1:0] ch, input logic [7:0] d,
                        input logic s, input logic e, input logic er);
        @(negedge clk);
        in_valid = 1'b1; in_channel = ch; in_data = d;
        in_sop = s; in_eop = e; in_error = er;
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int rdy;
        int got;
        logic [31:0] first, last;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state
        @(negedge clk);
        check("R1 ready after reset", {31'b0, in_ready}, 32'd0);
        csr_rd(4'h0, v); check("R12 ctrl reset", v, 32'd0);
        csr_rd(4'h4, v); check("R12 info", v, 32'h0001_0004);
        csr_rd(4'h8, v); check("R11 empty read", v, 32'd0);

        // R3: beats offered while disabled are ignored
        @(negedge clk);
        in_valid = 1'b1; in_channel = 2'd0; in_data = 8'd99; in_sop = 1'b0;
        rdy = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (in_ready) rdy++;
        end
        in_valid = 1'b0;
        check("R1 disabled ready count", rdy, 0);
        csr_rd(4'h8, v); check("R3 ignored beats queue nothing", v, 32'd0);

        // enable with throttle 255
        csr_wr(4'h0, 32'h0000_FF01);
        csr_rd(4'h0, v); check("R12 ctrl readback", v, 32'h0000_FF01);

        // vector table walk
        for (int i = 0; i < NV; i++) begin
            send(VECS[i].ch, VECS[i].d, VECS[i].sop, VECS[i].eop, VECS[i].err);
            csr_rd(4'h8, v);
            check($sformatf("R4-vector%0d R11 descriptor", i), v,
                  (VECS[i].exp == 4'd0) ? 32'd0 :
                  {16'b0, 6'b0, VECS[i].ch, 4'b0, VECS[i].exp});
        end

        // R2: throttle window counts
        csr_wr(4'h0, 32'h0000_4001);
        rdy = 0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            if (in_ready) rdy++;
        end
        check("R2 throttle 64", rdy, 64);
        csr_wr(4'h0, 32'h0000_0001);
        rdy = 0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            if (in_ready) rdy++;
        end
        check("R2 throttle 0", rdy, 0);
        csr_wr(4'h0, 32'h0000_FF00);
        rdy = 0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            if (in_ready) rdy++;
        end
        check("R1 disabled throttle 255", rdy, 0);

        // R10: overfill the queue with alternating types
        csr_wr(4'h0, 32'h0000_FF01);
        for (int i = 0; i < 20; i++) begin
            send(2'd1, 8'd0, 1'b0, 1'b0, 1'b0);  // missing start
            send(2'd1, 8'd0, 1'b1, 1'b1, 1'b1);  // input error
        end
        got = 0; first = '0; last = '0;
        for (int i = 0; i < 33; i++) begin
            csr_rd(4'h8, v);
            if (v != 32'd0) begin
                if (got == 0) first = v;
                last = v;
                got++;
            end
        end
        check("R10 stored entries", got, 32);
        check("R10 oldest entry", first, 32'h0000_0102);
        check("R10 youngest kept", last, 32'h0000_0104);
        csr_rd(4'h8, v); check("R11 read after drain", v, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule